// File: doc/BRIEF.md
# Multichannel PCM Block DMA with Per-Channel Sample Delay

This block feeds an audio serializer from a circular sample buffer held in a 24-bit data memory, with no processor action per sample. Software fills the buffer with frames of interleaved samples, one word per channel. At address `base + frame*NCH + channel` each frame holds one sample for every channel. On each frame request from the serializer, the block reads the eight words it needs, one per cycle, through a memory port with one cycle of read latency. It then presents all channels together in an output register and pulses a valid strobe.

Each channel can lag the others by a programmable whole number of sample periods, from 0 to 255. The block does this by reading that channel's word from an earlier frame of the circular buffer, so the software that writes samples does not take part. Before enough frames have been played to cover a channel's delay, that channel outputs silence. When the buffer's last frame has been delivered, the frame pointer returns to the first frame and a block-done interrupt pulses.

Top module: `pcm_dma`

## Requirements
- R1: After reset, `pcm_valid`, `blk_done_irq` and `mem_rd` are 0 and `pcm_data` is all zeros.
- R2: Each accepted frame request issues exactly NCH reads on consecutive cycles, in ascending channel order. Channel c's read uses address `cfg_base + s*NCH + c`, where s is the frame selected for that channel.
- R3: `pcm_valid` is a one-cycle pulse that rises on the (NCH+1)-th rising edge after the edge that samples `frame_req`. Channel c occupies `pcm_data[c*24 +: 24]`. Between pulses, `pcm_data` does not change.
- R4: With the current frame index f, block length L (1 to 255) and a channel delay d below L, the selected frame is (f − d) mod L. The delay of channel c is `cfg_delay[c*8 +: 8]`.
- R5: A channel whose delay exceeds the number of frames delivered since enable outputs 0.
- R6: Delays are captured when a request is accepted. A change during a fetch first affects the next frame.
- R7: Delivering frame L−1 pulses `blk_done_irq` together with that frame's `pcm_valid`, and the next frame index is 0.
- R8: A `frame_req` that arrives while a fetch is in progress, or while `dma_en` is 0, is ignored. It produces no reads and no output.
- R9: With `dma_en` at 0, the block stops reading on the next cycle, drops any partial frame, and clears its frame index and delivered-frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Run enable; low holds the engine idle and clears its position |
| frame_req | input | 1 | Serializer request for the next frame |
| cfg_base | input | ADDR_W | Buffer start address |
| cfg_blk_len | input | LEN_W | Buffer length in frames (0 acts as 1) |
| cfg_delay | input | NCH*DLY_W | Per-channel delay in frames |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 24 | Read data, valid one cycle after the strobe |
| pcm_data | output | NCH*24 | Latest complete frame, channel c in slice c |
| pcm_valid | output | 1 | One-cycle strobe marking a new frame |
| blk_done_irq | output | 1 | One-cycle pulse on buffer wrap |

## Verification
The hardest state to reach is the silent-to-audible transition of delayed channels. It occurs only after a fresh enable, when the delivered-frame count is still below some channel delays, and it must be combined with a read index that wraps below zero. The stimulus disables and re-enables the engine with a short block and mixed delays up to L−1. It then plays more frames than the block holds, so each channel in turn leaves silence and reads back across the wrap point. Mid-fetch delay changes and aborts are timed by counting edges after the accepted request.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;
    localparam int SAMPLE_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/pcm_dma_frame_ctr.sv
// Tracks the current frame index inside the circular buffer and the
// saturating number of frames delivered since enable.
module pcm_dma_frame_ctr #(
    parameter int LEN_W = 8,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [LEN_W-1:0] len_eff,
    output logic [LEN_W-1:0] idx,
    output logic [DLY_W-1:0] filled,
    output logic             wrap
);
    localparam logic [DLY_W-1:0] FILL_MAX = '1;

    typedef struct packed {
        logic [LEN_W-1:0] idx;
        logic [DLY_W-1:0] filled;
        logic             wrap;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d      = ctr_q;
        ctr_d.wrap = 1'b0;
        if (clr) begin
            ctr_d.idx    = '0;
            ctr_d.filled = '0;
        end else if (adv) begin
            if (ctr_q.idx >= len_eff - LEN_W'(1)) begin
                ctr_d.idx  = '0;
                ctr_d.wrap = 1'b1;
            end else begin
                ctr_d.idx = ctr_q.idx + LEN_W'(1);
            end
            if (ctr_q.filled != FILL_MAX) begin
                ctr_d.filled = ctr_q.filled + DLY_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign idx    = ctr_q.idx;
    assign filled = ctr_q.filled;
    assign wrap   = ctr_q.wrap;
endmodule

// File: rtl/pcm_dma_delay_calc.sv
// For one channel: which buffer frame to read, and whether the
// channel is still silent because its delay is not yet covered.
module pcm_dma_delay_calc #(
    parameter int LEN_W = 8,
    parameter int DLY_W = 8
) (
    input  logic [LEN_W-1:0] idx,
    input  logic [LEN_W-1:0] len_eff,
    input  logic [DLY_W-1:0] delay,
    input  logic [DLY_W-1:0] filled,
    output logic [LEN_W-1:0] sel,
    output logic             silent
);
    localparam int WW = ((LEN_W > DLY_W) ? LEN_W : DLY_W) + 1;

    logic [WW-1:0] idx_w, len_w, dly_w;

    always_comb begin
        idx_w  = WW'(idx);
        len_w  = WW'(len_eff);
        dly_w  = WW'(delay);
        silent = delay > filled;
        if (idx_w >= dly_w) begin
            sel = LEN_W'(idx_w - dly_w);
        end else begin
            sel = LEN_W'(idx_w + len_w - dly_w);
        end
    end
endmodule

// File: rtl/pcm_dma.sv
module pcm_dma
    import pcm_dma_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 8,
    parameter int DLY_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dma_en,
    input  logic                    frame_req,
    input  logic [ADDR_W-1:0]       cfg_base,
    input  logic [LEN_W-1:0]        cfg_blk_len,
    input  logic [NCH*DLY_W-1:0]    cfg_delay,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_rd,
    input  logic [SAMPLE_W-1:0]     mem_rdata,
    output logic [NCH*SAMPLE_W-1:0] pcm_data,
    output logic                    pcm_valid,
    output logic                    blk_done_irq
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

    typedef struct packed {
        fetch_st_e                        st;
        logic [CH_W-1:0]                  ch;
        logic [NCH-1:0][DLY_W-1:0]        dly;
        logic                             cap_vld;
        logic [CH_W-1:0]                  cap_ch;
        logic                             cap_zero;
        logic [NCH-1:0][SAMPLE_W-1:0]     work;
        logic [NCH-1:0][SAMPLE_W-1:0]     out;
        logic                             valid;
    } fetch_t;

    fetch_t f_d, f_q;

    logic [LEN_W-1:0]            len_eff;
    logic [LEN_W-1:0]            frm_idx;
    logic [DLY_W-1:0]            frm_filled;
    logic                        frm_wrap;
    logic                        frm_adv;
    logic [NCH-1:0][DLY_W-1:0]   dly_in;
    logic [NCH-1:0][LEN_W-1:0]   sel_all;
    logic [NCH-1:0]              silent_all;

    assign len_eff = (cfg_blk_len == '0) ? LEN_W'(1) : cfg_blk_len;
    assign dly_in  = cfg_delay;
    assign frm_adv = dma_en && f_q.cap_vld && (f_q.cap_ch == CH_LAST);

    pcm_dma_frame_ctr #(
        .LEN_W (LEN_W),
        .DLY_W (DLY_W)
    ) i_frame_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!dma_en),
        .adv     (frm_adv),
        .len_eff (len_eff),
        .idx     (frm_idx),
        .filled  (frm_filled),
        .wrap    (frm_wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pcm_dma_delay_calc #(
            .LEN_W (LEN_W),
            .DLY_W (DLY_W)
        ) i_delay_calc (
            .idx     (frm_idx),
            .len_eff (len_eff),
            .delay   (f_q.dly[g]),
            .filled  (frm_filled),
            .sel     (sel_all[g]),
            .silent  (silent_all[g])
        );
    end

    always_comb begin
        f_d         = f_q;
        f_d.valid   = 1'b0;
        f_d.cap_vld = 1'b0;
        mem_rd      = 1'b0;
        mem_addr    = '0;

        if (!dma_en) begin
            f_d.st = ST_IDLE;
        end else begin
            // capture the word requested one cycle earlier
            if (f_q.cap_vld) begin
                f_d.work[f_q.cap_ch] = f_q.cap_zero ? '0 : mem_rdata;
                if (f_q.cap_ch == CH_LAST) begin
                    f_d.out   = f_d.work;
                    f_d.valid = 1'b1;
                end
            end

            unique case (f_q.st)
                ST_IDLE: begin
                    if (frame_req) begin
                        f_d.st  = ST_FETCH;
                        f_d.ch  = '0;
                        f_d.dly = dly_in;
                    end
                end
                ST_FETCH: begin
                    mem_rd       = 1'b1;
                    mem_addr     = ADDR_W'(cfg_base
                                 + ADDR_W'(sel_all[f_q.ch]) * ADDR_W'(NCH)
                                 + ADDR_W'(f_q.ch));
                    f_d.cap_vld  = 1'b1;
                    f_d.cap_ch   = f_q.ch;
                    f_d.cap_zero = silent_all[f_q.ch];
                    if (f_q.ch == CH_LAST) begin
                        f_d.st = ST_DRAIN;
                    end else begin
                        f_d.ch = f_q.ch + CH_W'(1);
                    end
                end
                ST_DRAIN: begin
                    f_d.st = ST_IDLE;
                end
                default: begin
                    f_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign pcm_data     = f_q.out;
    assign pcm_valid    = f_q.valid;
    assign blk_done_irq = frm_wrap;
endmodule

// File: rtl/pcm_dma_chk.sv
module pcm_dma_chk #(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 8,
    parameter int SW     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_en,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [LEN_W-1:0]  cfg_blk_len,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NCH*SW-1:0] pcm_data,
    input logic              pcm_valid,
    input logic              blk_done_irq
);
    logic [31:0] rd_cnt;
    logic [31:0] rd_off;
    logic [31:0] rd_lim;

    assign rd_off = 32'(mem_addr) - 32'(cfg_base);
    assign rd_lim = ((cfg_blk_len == '0) ? 32'd1 : 32'(cfg_blk_len)) * 32'(NCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= '0;
        end else if (!dma_en || pcm_valid) begin
            rd_cnt <= '0;
        end else if (mem_rd) begin
            rd_cnt <= rd_cnt + 32'd1;
        end
    end

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_valid |-> $stable(pcm_data));

    assert_irq_with_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_irq |-> pcm_valid);

    assert_addr_in_buffer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> rd_off < rd_lim);

    assert_reads_per_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> rd_cnt == 32'(NCH));

    assert_stop_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !mem_rd);
endmodule

bind pcm_dma pcm_dma_chk #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .SW     (24)
) i_pcm_dma_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_en       (dma_en),
    .cfg_base     (cfg_base),
    .cfg_blk_len  (cfg_blk_len),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .pcm_data     (pcm_data),
    .pcm_valid    (pcm_valid),
    .blk_done_irq (blk_done_irq)
);

// File: tb/test_pcm_dma.sv
module test_pcm_dma;
    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 8;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 8;
    localparam int DLY_W  = 8;

    typedef struct {
        logic [NCH*24-1:0] data;
        logic              irq;
        string             tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 dma_en = 1'b0;
    logic                 frame_req = 1'b0;
    logic [ADDR_W-1:0]    cfg_base = '0;
    logic [LEN_W-1:0]     cfg_blk_len = 8'd1;
    logic [NCH*DLY_W-1:0] cfg_delay = '0;
    logic [ADDR_W-1:0]    mem_addr;
    logic                 mem_rd;
    logic [23:0]          mem_rdata = '0;
    logic [NCH*24-1:0]    pcm_data;
    logic                 pcm_valid;
    logic                 blk_done_irq;

    int   errors = 0;
    int   checks = 0;
    int   valid_seen = 0;
    int   rd_seen = 0;
    bit   addr_chk_on = 1'b1;
    int   m_idx = 0;
    int   m_filled = 0;
    exp_t exp_q[$];
    logic [ADDR_W-1:0] addr_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_dma #(
        .NCH (NCH), .ADDR_W (ADDR_W), .LEN_W (LEN_W), .DLY_W (DLY_W)
    ) i_pcm_dma (
        .clk (clk), .rst_n (rst_n), .dma_en (dma_en), .frame_req (frame_req),
        .cfg_base (cfg_base), .cfg_blk_len (cfg_blk_len), .cfg_delay (cfg_delay),
        .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_rdata (mem_rdata),
        .pcm_data (pcm_data), .pcm_valid (pcm_valid), .blk_done_irq (blk_done_irq)
    );

    function automatic logic [23:0] memval(input int a);
        return 24'((a * 4099) ^ 24'h5A5A5A);
    endfunction

    // memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= memval(int'(mem_addr));
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [191:0] act, input logic [191:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // monitor: compare frames and read addresses against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                rd_seen++;
                if (addr_chk_on) begin
                    if (addr_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected read", 192'(mem_addr), '0);
                    end else begin
                        logic [ADDR_W-1:0] ea;
                        ea = addr_q.pop_front();
                        check(mem_addr == ea, "R2", "read address",
                              192'(mem_addr), 192'(ea));
                    end
                end
            end
            if (pcm_valid) begin
                valid_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected frame", pcm_data, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(pcm_data == e.data, e.tag, "frame data", pcm_data, e.data);
                    check(blk_done_irq == e.irq, "R7", "block done", 192'(blk_done_irq),
                          192'(e.irq));
                end
            end else if (blk_done_irq) begin
                check(1'b0, "R7", "irq without frame", 192'(1), 192'(0));
            end
        end
    end

    task automatic model_reset();
        m_idx = 0;
        m_filled = 0;
    endtask

    // one frame: push expectations, request, measure latency
    task automatic do_frame(input string tag, input int chg_at,
                            input logic [NCH*DLY_W-1:0] new_dly, input bit extra_req);
        exp_t e;
        int   len;
        int   k;
        len = (cfg_blk_len == 0) ? 1 : int'(cfg_blk_len);
        e.tag = tag;
        for (int c = 0; c < NCH; c++) begin
            int d;
            int s;
            int a;
            d = int'(cfg_delay[c*DLY_W +: DLY_W]);
            s = (m_idx >= d) ? m_idx - d : m_idx + len - d;
            a = int'(cfg_base) + s * NCH + c;
            addr_q.push_back(ADDR_W'(a));
            e.data[c*24 +: 24] = (d > m_filled) ? 24'd0 : memval(a);
        end
        e.irq = (m_idx == len - 1);
        exp_q.push_back(e);
        m_idx = e.irq ? 0 : m_idx + 1;
        if (m_filled < 255) m_filled++;

        @(negedge clk) frame_req = 1'b1;
        @(posedge clk);
        @(negedge clk) frame_req = 1'b0;
        k = 0;
        while (k < 40) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (k == chg_at) cfg_delay = new_dly;
            if (extra_req && k == 2) frame_req = 1'b1;
            if (extra_req && k == 4) frame_req = 1'b0;
            if (pcm_valid) break;
        end
        check(k == NCH + 1, "R3", "valid latency", 192'(k), 192'(NCH + 1));
        @(negedge clk);
        check(!pcm_valid, "R3", "valid is one cycle", 192'(pcm_valid), 192'(0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int vs;
        int rs;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!pcm_valid && !blk_done_irq && !mem_rd && pcm_data == '0, "R1",
              "reset outputs", {pcm_data[188:0], pcm_valid, blk_done_irq, mem_rd}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R7: plain block transfer, no delay, wraps at frame 3
        cfg_base = 12'h040;
        cfg_blk_len = 8'd4;
        cfg_delay = '0;
        dma_en = 1'b1;
        for (int i = 0; i < 5; i++) do_frame("R2", -1, '0, 1'b0);

        // R9 restart, then R4/R5 mixed delays across the wrap
        @(negedge clk) dma_en = 1'b0;
        @(negedge clk);
        model_reset();
        cfg_base = 12'h100;
        cfg_blk_len = 8'd6;
        cfg_delay = {8'd1, 8'd4, 8'd0, 8'd5, 8'd3, 8'd2, 8'd1, 8'd0};
        dma_en = 1'b1;
        for (int i = 0; i < 9; i++) do_frame("R4 R5", -1, '0, 1'b0);

        // R6: delay change during a fetch applies only to the next frame
        do_frame("R6", 3, {8'd0, 8'd2, 8'd5, 8'd1, 8'd0, 8'd4, 8'd3, 8'd2}, 1'b0);
        do_frame("R6", -1, '0, 1'b0);

        // R8: request inside a fetch is ignored
        do_frame("R8", -1, '0, 1'b1);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R8", "pending frames after busy request",
              192'(exp_q.size()), 192'(0));

        // R8: request while disabled is ignored
        @(negedge clk) dma_en = 1'b0;
        vs = valid_seen;
        rs = rd_seen;
        @(negedge clk) frame_req = 1'b1;
        @(negedge clk) frame_req = 1'b0;
        repeat (20) @(negedge clk);
        check(valid_seen == vs && rd_seen == rs, "R8", "activity while disabled",
              192'(valid_seen - vs + rd_seen - rs), 192'(0));

        // R9: abort mid-fetch, then restart from frame 0 with nothing delivered
        dma_en = 1'b1;
        addr_chk_on = 1'b0;
        vs = valid_seen;
        @(negedge clk) frame_req = 1'b1;
        @(negedge clk) frame_req = 1'b0;
        repeat (3) @(negedge clk);
        dma_en = 1'b0;
        @(negedge clk);
        check(!mem_rd, "R9", "read after disable", 192'(mem_rd), 192'(0));
        repeat (15) @(negedge clk);
        check(valid_seen == vs, "R9", "aborted frame delivered",
              192'(valid_seen - vs), 192'(0));
        model_reset();
        addr_chk_on = 1'b1;
        dma_en = 1'b1;
        do_frame("R9", -1, '0, 1'b0);
        do_frame("R9", -1, '0, 1'b0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && addr_q.size() == 0, "R2", "scoreboard drained",
              192'(exp_q.size() + addr_q.size()), 192'(0));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule